// File: doc/BRIEF.md
# Successive-Approximation Conversion Timer

This block paces one 8-bit successive-approximation conversion from the system clock. A 5-bit divider code sets the rate of a converter-clock enable. The enable is a single-cycle strobe, not a second clock. A 2-bit sampling code sets how many converter clocks the input is held in sample. After sampling, the block tests the result bits one at a time, starting with the most significant bit. It drives a trial code to an external DAC and reads back a 1-bit comparator decision.

A conversion starts with a one-cycle `start_i` pulse while the block is idle. Both codes are captured at that moment. The block then raises `sample_en_o` for the sampling phase and runs eight two-clock bit decisions. It finishes by pulsing `done_o` for one system clock and presenting the code on `result_o`. That code stays unchanged until the next conversion completes. The comparator and the DAC are outside the block.

Top module: `adc_sar_timer`

## Requirements
- R1: Divider codes 0 to 7 (upper two code bits zero) give a converter-clock strobe every 2×(code+1) system clocks, counted from the accepted start.
- R2: Any divider code with bit 4 or bit 3 set is reserved, and the block divides by 16.
- R3: `sample_en_o` rises in the cycle after an accepted start. It stays high for S converter clocks, where S is 2, 4, 8 or 16 for sampling codes 0, 1, 2 and 3. `dac_code_o` is zero while sampling.
- R4: `done_o` is high exactly (S+16)×D system clocks after the clock edge that accepts start, where D is the divisor. This gives 18, 20, 24 or 32 converter clocks in total.
- R5: The first trial code after sampling is 0x80. A trial bit is kept when `cmp_i` is 1 (input at or above the trial level) and cleared otherwise. The next lower bit is then set. For an ideal input v in steps of full-scale/256, the result is v.
- R6: Each bit decision spans two converter clocks. Each trial code is held for 2×D system clocks, and the decision is taken at the second strobe.
- R7: `done_o` is a one-cycle pulse. `result_o` changes only in the cycle where `done_o` is high.
- R8: A start while a conversion runs is ignored. Code inputs that change during a conversion do not affect its timing.
- R9: After reset, `sample_en_o`, `done_o`, `dac_code_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured only when idle |
| div_code_i | input | 5 | Converter-clock divider code |
| smp_code_i | input | 2 | Sampling-length code |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the trial code |
| sample_en_o | output | 1 | High during the sampling phase |
| dac_code_o | output | 8 | Trial code for the external DAC |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| result_o | output | 8 | Final conversion code |

## Verification
A divider counter or sampling counter that runs off its intended value moves the `done_o` pulse by whole converter-clock multiples. That shift shows up at the end of the first conversion. It also stretches or shortens the `sample_en_o` window from the first phase onward. A wrong bit index or a wrong keep/clear decision shows up two converter clocks after sampling, because the second trial code is 0x40 or 0xC0 instead. It also produces a wrong result code at `done_o`. A start that leaks through while the block is busy restarts the sampling phase. That pushes `done_o` later than the expected count.

// File: rtl/adc_timing_pkg.sv
package adc_timing_pkg;

  localparam int DIV_CODE_W = 5;
  localparam int SMP_CODE_W = 2;
  localparam int MAX_DIV    = 16;
  localparam int DIV_W      = $clog2(MAX_DIV) + 1;
  localparam int SMP_W      = 5;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAMPLE  = 2'd1,
    PH_CONVERT = 2'd2
  } phase_t;

  // Even divisor 2*(code+1); codes with either upper bit set fall back to 16.
  function automatic logic [DIV_W-1:0] div_from_code(input logic [DIV_CODE_W-1:0] code);
    if (code[DIV_CODE_W-1:DIV_CODE_W-2] != 2'b00)
      return DIV_W'(MAX_DIV);
    return DIV_W'({code[2:0], 1'b0}) + DIV_W'(2);
  endfunction

  // Sampling length in converter clocks: 2, 4, 8, 16.
  function automatic logic [SMP_W-1:0] smp_from_code(input logic [SMP_CODE_W-1:0] code);
    return SMP_W'(2) << code;
  endfunction

endpackage

// File: rtl/adc_clk_divider.sv
module adc_clk_divider
  import adc_timing_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic [DW-1:0] divisor_i,
  output logic          tick_o
);

  localparam int CW = DW - 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = ({1'b0, cnt_q} == divisor_i - DW'(1));
  assign tick_o = run_i && !clear_i && wrap;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)
      cnt_q <= '0;
    else if (clear_i)
      cnt_q <= '0;
    else if (run_i)
      cnt_q <= wrap ? '0 : cnt_q + CW'(1);
  end

  // R1: strobes are never adjacent, since every divisor is at least 2
  assert_tick_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R2: the count never passes the selected divisor
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> ({1'b0, cnt_q} < divisor_i));

endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer
  import adc_timing_pkg::*;
#(
  parameter int RES_W = 8,
  parameter int SW    = SMP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [SW-1:0]    smp_ticks_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             start_acc_o,
  output logic             sample_en_o,
  output logic [RES_W-1:0] trial_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);

  localparam int IDX_W = $clog2(RES_W);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  phase_t           phase_q;
  logic [SW-1:0]    cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             half_q;
  logic [RES_W-1:0] code_q;
  logic [RES_W-1:0] result_q;
  logic             done_q;

  logic             last_sample;
  logic             decide;
  logic             last_bit;
  logic [RES_W-1:0] code_next;

  // Settle bit i from the comparator, then propose the next lower bit.
  function automatic logic [RES_W-1:0] sar_step(input logic [RES_W-1:0] c,
                                                input logic [IDX_W-1:0] i,
                                                input logic             keep);
    logic [RES_W-1:0] r;
    r    = c;
    r[i] = keep;
    if (i != '0) r[i - IDX_W'(1)] = 1'b1;
    return r;
  endfunction

  assign start_acc_o = start_i && (phase_q == PH_IDLE);
  assign last_sample = tick_i && (phase_q == PH_SAMPLE) && (cnt_q == smp_ticks_i - SW'(1));
  assign decide      = tick_i && (phase_q == PH_CONVERT) && half_q;
  assign last_bit    = decide && (idx_q == '0);
  assign code_next   = sar_step(code_q, idx_q, cmp_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      half_q   <= 1'b0;
      code_q   <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_SAMPLE;
            cnt_q   <= '0;
            code_q  <= '0;
          end
        end
        PH_SAMPLE: begin
          if (last_sample) begin
            phase_q <= PH_CONVERT;
            code_q  <= MSB_ONLY;
            idx_q   <= IDX_W'(RES_W - 1);
            half_q  <= 1'b0;
          end else if (tick_i) begin
            cnt_q <= cnt_q + SW'(1);
          end
        end
        PH_CONVERT: begin
          if (tick_i && !half_q) begin
            half_q <= 1'b1;
          end else if (decide) begin
            half_q <= 1'b0;
            if (last_bit) begin
              phase_q  <= PH_IDLE;
              result_q <= code_next;
              done_q   <= 1'b1;
              code_q   <= '0;
            end else begin
              code_q <= code_next;
              idx_q  <= idx_q - IDX_W'(1);
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o      = (phase_q != PH_IDLE);
  assign sample_en_o = (phase_q == PH_SAMPLE);
  assign trial_o     = code_q;
  assign done_o      = done_q;
  assign result_o    = result_q;

  // R7: the end-of-conversion pulse lasts a single cycle
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7: the result register moves only together with done
  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  // R5: the bit search starts from the most significant bit
  assert_msb_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_q == PH_CONVERT) |-> (trial_o == MSB_ONLY));

  // R3: no trial code is driven while sampling
  assert_quiet_dac_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_en_o |-> (trial_o == '0));

  // R6: a trial code only changes on a deciding strobe or when sampling ends
  assert_trial_steady_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CONVERT && !decide) |=> $stable(trial_o));

endmodule

// File: rtl/adc_sar_timer.sv
module adc_sar_timer
  import adc_timing_pkg::*;
#(
  parameter int RES_W = 8,
  parameter int DCW   = DIV_CODE_W,
  parameter int SCW   = SMP_CODE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DCW-1:0]   div_code_i,
  input  logic [SCW-1:0]   smp_code_i,
  input  logic             cmp_i,
  output logic             sample_en_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);

  logic [DCW-1:0]   div_code_q;
  logic [SCW-1:0]   smp_code_q;
  logic [DIV_W-1:0] divisor;
  logic [SMP_W-1:0] smp_ticks;
  logic             busy;
  logic             start_acc;
  logic             tick;

  // Codes are captured once per conversion; divide-by-4 after reset.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      div_code_q <= DCW'(1);
      smp_code_q <= '0;
    end else if (start_acc) begin
      div_code_q <= div_code_i;
      smp_code_q <= smp_code_i;
    end
  end

  assign divisor   = div_from_code(div_code_q);
  assign smp_ticks = smp_from_code(smp_code_q);

  adc_clk_divider #(
    .DW (DIV_W)
  ) i_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_acc),
    .run_i     (busy),
    .divisor_i (divisor),
    .tick_o    (tick)
  );

  adc_sar_sequencer #(
    .RES_W (RES_W),
    .SW    (SMP_W)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .tick_i      (tick),
    .smp_ticks_i (smp_ticks),
    .cmp_i       (cmp_i),
    .busy_o      (busy),
    .start_acc_o (start_acc),
    .sample_en_o (sample_en_o),
    .trial_o     (dac_code_o),
    .done_o      (done_o),
    .result_o    (result_o)
  );

  // R8: a start during a conversion leaves the captured codes alone
  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy) |=> ($stable(div_code_q) && $stable(smp_code_q)));

  // R4: a conversion cannot finish on the cycle it begins
  assert_no_instant_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_acc |=> !done_o);

endmodule

// File: tb/test_adc_sar_timer.sv
`timescale 1ns/1ps
module test_adc_sar_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] dcode = 5'd0;
  logic [1:0] scode = 2'd0;
  logic [7:0] vin = 8'd0;
  logic       cmp;
  logic       sample_en;
  logic [7:0] dac;
  logic       done;
  logic [7:0] result;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // Ideal comparator: input at or above the trial level.
  assign cmp = (vin >= dac);

  adc_sar_timer i_adc_sar_timer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .div_code_i  (dcode),
    .smp_code_i  (scode),
    .cmp_i       (cmp),
    .sample_en_o (sample_en),
    .dac_code_o  (dac),
    .done_o      (done),
    .result_o    (result)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_div(input logic [4:0] c);
    return (c > 5'd7) ? 16 : 2 * int'(c) + 2;
  endfunction

  function automatic int exp_smp(input logic [1:0] c);
    int s = 2;
    for (int i = 0; i < int'(c); i++) s = s * 2;
    return s;
  endfunction

  // One conversion; optional stray start with other codes while busy.
  task automatic run_conv(input logic [4:0] dc, input logic [1:0] sc, input logic [7:0] v,
                          input string req, input bit poke);
    int d = exp_div(dc);
    int s = exp_smp(sc);
    int k = 0;
    int smp_cycles = 0;
    int done_at = -1;
    logic [7:0] second = (v >= 8'h80) ? 8'hC0 : 8'h40;
    @(negedge clk);
    vin = v; dcode = dc; scode = sc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (k < 2000) begin
      if (sample_en) smp_cycles++;
      if (k == s * d)
        chk(dac == 8'h80, "R5", "first trial code", dac, 8'h80);
      if (k == s * d + 2 * d - 1)
        chk(dac == 8'h80, "R6", "trial held to second strobe", dac, 8'h80);
      if (k == s * d + 2 * d)
        chk(dac == second, "R6", "second trial code", dac, second);
      if (done) begin done_at = k; break; end
      if (poke && k == 5) begin start = 1'b1; dcode = 5'd0; scode = 2'd0; end
      if (poke && k == 6) start = 1'b0;
      @(negedge clk);
      k++;
    end
    chk(done_at == (s + 16) * d, req, "done cycle", done_at, (s + 16) * d);
    chk(smp_cycles == s * d, "R3", "sample_en length", smp_cycles, s * d);
    chk(result == v, "R5", "result code", result, v);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done width", done, 0);
  endtask

  task automatic reset_state;
    chk(sample_en == 1'b0 && done == 1'b0, "R9", "sample_en/done at reset", {sample_en, done}, 0);
    chk(dac == 8'd0, "R9", "dac at reset", dac, 0);
    chk(result == 8'd0, "R9", "result at reset", result, 0);
  endtask

  task automatic hold_result;
    logic [7:0] kept = result;
    bit moved = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      vin = 8'(i * 7);
      if (result != kept || done) moved = 1'b1;
    end
    chk(!moved, "R7", "result held between conversions", result, kept);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    run_conv(5'd0, 2'd0, 8'd0,   "R1", 1'b0); // R1: divide by 2, zero input
    run_conv(5'd1, 2'd1, 8'd128, "R1", 1'b0); // R1: divide by 4, mid-scale
    run_conv(5'd7, 2'd3, 8'd255, "R4", 1'b0); // R4: longest 32-clock conversion, full scale
    run_conv(5'd3, 2'd2, 8'h5A,  "R4", 1'b0); // R4: 24-clock conversion
    run_conv(5'b01010, 2'd0, 8'h33, "R2", 1'b0); // R2: reserved code
    run_conv(5'b11111, 2'd1, 8'hA7, "R2", 1'b0); // R2: reserved code
    run_conv(5'b10000, 2'd0, 8'h01, "R2", 1'b0); // R2: reserved code
    hold_result();                                // R7
    run_conv(5'd2, 2'd1, 8'h7F, "R8", 1'b1);      // R8: stray start ignored
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule